// File: doc/BRIEF.md
# Mode-Banked High-Voltage Parameter Registers

This block holds the settings that drive a display's high-voltage generator. There are two complete copies of these settings. One copy serves the full-screen (normal) display mode. The other serves the partial display mode. Each copy has four fields: a range select, an operating-voltage code, a bias code and a charge-pump code.

Command writes for both copies use the same field codes. The level of the mode input decides which copy a write updates. The registered outputs always present the copy that matches the mode input. A single change of mode therefore reconfigures the generator, and no further commands are needed.

Parameter writes are guarded by an extended-command qualifier. Writes to the partial-zone code are not guarded. That code is decoded into the row counts of the two partial display sections. A read-back port returns any field of the copy that is currently selected.

Top module: `hv_param_banks`

## Requirements
- R1: During reset the outputs `hv_rsel`, `hv_vop`, `hv_bias`, `hv_pump`, `mode_q` and `rd_data` all read 0. The zone code also clears to 0, so `sec1_rows` = 0 and `sec2_rows` = 8. Both parameter copies clear to zero.
- R2: A parameter write that is accepted while `mode_i` = 0 updates only the normal copy. The partial copy is left unchanged.
- R3: A parameter write that is accepted while `mode_i` = 1 updates only the partial copy. The normal copy is left unchanged.
- R4: `cmd_kind` selects the target field: 2 = range select, 3 = voltage, 4 = bias, 5 = charge pump. A field takes the low bits of `cmd_data`, as many as its width (2, 7, 3 and 3 bits).
- R5: One clock edge after `mode_i` changes, `mode_q` equals the new mode. In that same cycle all four output fields show the newly selected copy.
- R6: A parameter write is accepted only if `ext_flag` is 1 in the write cycle and was also 1 in the sampled cycle before it. Any other parameter write leaves both copies unchanged.
- R7: `rd_data` returns the field chosen by `rd_sel` (0 = range, 1 = voltage, 2 = bias, 3 = pump), zero-extended. It reads from the copy selected by `mode_i` and appears one edge after `rd_sel` is sampled.
- R8: `cmd_kind` = 1 writes the 3-bit zone code from `cmd_data[2:0]`, whatever the value of `ext_flag`. The codes 0 to 7 map to (section 1, section 2) rows as follows: 0→(0,8), 1→(8,0), 2→(8,8), 3→(0,16), 4→(16,0), 5→(8,16), 6→(16,8), 7→(16,16).
- R9: Suppose a write is accepted in the same cycle that `mode_i` switches to the bank being written. On the next edge the outputs show the switched bank with that write already applied.
- R10: Writes with `cmd_kind` equal to 0, 6 or 7 have no effect on any output or stored field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded command write strobe |
| cmd_kind | input | 3 | Field code of the command |
| cmd_data | input | 7 | Command data |
| ext_flag | input | 1 | Extended-command qualifier level |
| mode_i | input | 1 | Display mode: 0 normal, 1 partial |
| rd_sel | input | 2 | Read-back field select |
| hv_rsel | output | 2 | Active range select |
| hv_vop | output | 7 | Active operating-voltage code |
| hv_bias | output | 3 | Active bias code |
| hv_pump | output | 3 | Active charge-pump code |
| mode_q | output | 1 | Registered mode the outputs belong to |
| rd_data | output | 7 | Read-back data |
| zone_code | output | 3 | Stored partial-zone code |
| sec1_rows | output | 5 | Rows of partial section 1 |
| sec2_rows | output | 5 | Rows of partial section 2 |

## Verification
Two things can happen at the same edge: a change of `mode_i` that swaps the active copy, and an accepted field write aimed at the copy being selected. The bench arms the qualifier and then raises `mode_i` in the very cycle that it writes a new voltage. One edge later it expects the partial copy's other fields, together with the new voltage rather than the stale one. A second scenario writes in the cycle the qualifier rises. It judges the write rejected by looking at the output voltage.

// File: rtl/hvp_pkg.sv
package hvp_pkg;
  localparam int RSEL_W = 2;
  localparam int VOP_W  = 7;
  localparam int BIAS_W = 3;
  localparam int PUMP_W = 3;

  typedef struct packed {
    logic [RSEL_W-1:0] rsel;
    logic [VOP_W-1:0]  vop;
    logic [BIAS_W-1:0] bias;
    logic [PUMP_W-1:0] pump;
  } hv_set_t;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_ZONE  = 3'd1,
    K_RSEL  = 3'd2,
    K_VOP   = 3'd3,
    K_BIAS  = 3'd4,
    K_PUMP  = 3'd5
  } cmd_kind_e;

  function automatic logic is_param_kind(input logic [2:0] k);
    return (k == K_RSEL) || (k == K_VOP) || (k == K_BIAS) || (k == K_PUMP);
  endfunction

  // Rows of section one for each zone code.
  function automatic logic [4:0] zone_first(input logic [2:0] c);
    logic [4:0] r;
    case (c)
      3'd0, 3'd3:         r = 5'd0;
      3'd1, 3'd2, 3'd5:   r = 5'd8;
      default:            r = 5'd16;
    endcase
    return r;
  endfunction

  // Rows of section two for each zone code.
  function automatic logic [4:0] zone_second(input logic [2:0] c);
    logic [4:0] r;
    case (c)
      3'd1, 3'd4:         r = 5'd0;
      3'd0, 3'd2, 3'd6:   r = 5'd8;
      default:            r = 5'd16;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hvp_cmd_gate.sv
module hvp_cmd_gate #(
  parameter int KIND_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [KIND_W-1:0] cmd_kind,
  input  logic              ext_flag,
  output logic              par_we,
  output logic              zone_we
);
  import hvp_pkg::*;

  logic ext_armed;

  // The qualifier counts as armed only if it was already high one cycle earlier.
  always_ff @(posedge clk) begin
    if (rst) ext_armed <= 1'b0;
    else     ext_armed <= ext_flag;
  end

  logic kind_param;
  logic kind_zone;

  always_comb begin
    kind_param = is_param_kind(3'(cmd_kind));
    kind_zone  = (3'(cmd_kind) == K_ZONE);
    par_we     = cmd_valid && kind_param && ext_flag && ext_armed;
    zone_we    = cmd_valid && kind_zone;
  end
endmodule

// File: rtl/hvp_bank.sv
module hvp_bank #(
  parameter int KIND_W = 3,
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [KIND_W-1:0] kind,
  input  logic [DATA_W-1:0] data,
  output hvp_pkg::hv_set_t  set_q,
  output hvp_pkg::hv_set_t  set_nxt
);
  import hvp_pkg::*;

  localparam int DW = (DATA_W > VOP_W) ? DATA_W : VOP_W;

  logic [DW-1:0] data_x;
  assign data_x = DW'(data);

  always_comb begin
    set_nxt = set_q;
    if (we) begin
      case (3'(kind))
        K_RSEL:  set_nxt.rsel = data_x[RSEL_W-1:0];
        K_VOP:   set_nxt.vop  = data_x[VOP_W-1:0];
        K_BIAS:  set_nxt.bias = data_x[BIAS_W-1:0];
        K_PUMP:  set_nxt.pump = data_x[PUMP_W-1:0];
        default: set_nxt = set_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) set_q <= '0;
    else     set_q <= set_nxt;
  end
endmodule

// File: rtl/hvp_out_stage.sv
module hvp_out_stage #(
  parameter int DATA_W = 7,
  parameter int SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode_i,
  input  logic [SEL_W-1:0]              rd_sel,
  input  hvp_pkg::hv_set_t [1:0]        bank_nxt,
  output hvp_pkg::hv_set_t              act_q,
  output logic                          mode_q,
  output logic [DATA_W-1:0]             rd_data
);
  import hvp_pkg::*;

  localparam int DW = (DATA_W > VOP_W) ? DATA_W : VOP_W;

  hv_set_t       pick;
  logic [DW-1:0] rd_mux;

  // Select from next-state values so a same-edge write is already visible.
  always_comb begin
    pick = bank_nxt[mode_i];
    case (2'(rd_sel))
      2'd0:    rd_mux = DW'(pick.rsel);
      2'd1:    rd_mux = DW'(pick.vop);
      2'd2:    rd_mux = DW'(pick.bias);
      default: rd_mux = DW'(pick.pump);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= '0;
      mode_q  <= 1'b0;
      rd_data <= '0;
    end else begin
      act_q   <= pick;
      mode_q  <= mode_i;
      rd_data <= rd_mux[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/hvp_zone.sv
module hvp_zone #(
  parameter int DATA_W = 7,
  parameter int ZONE_W = 3,
  parameter int ROWS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] data,
  output logic [ZONE_W-1:0] code_q,
  output logic [ROWS_W-1:0] sec1_q,
  output logic [ROWS_W-1:0] sec2_q
);
  import hvp_pkg::*;

  logic [ZONE_W-1:0] code_nxt;

  assign code_nxt = we ? data[ZONE_W-1:0] : code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      sec1_q <= ROWS_W'(zone_first(3'd0));
      sec2_q <= ROWS_W'(zone_second(3'd0));
    end else begin
      code_q <= code_nxt;
      sec1_q <= ROWS_W'(zone_first(3'(code_nxt)));
      sec2_q <= ROWS_W'(zone_second(3'(code_nxt)));
    end
  end
endmodule

// File: rtl/hv_param_banks.sv
module hv_param_banks #(
  parameter int KIND_W = 3,
  parameter int DATA_W = 7,
  parameter int SEL_W  = 2,
  parameter int ZONE_W = 3,
  parameter int ROWS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [KIND_W-1:0] cmd_kind,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              ext_flag,
  input  logic              mode_i,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [1:0]        hv_rsel,
  output logic [6:0]        hv_vop,
  output logic [2:0]        hv_bias,
  output logic [2:0]        hv_pump,
  output logic              mode_q,
  output logic [DATA_W-1:0] rd_data,
  output logic [ZONE_W-1:0] zone_code,
  output logic [ROWS_W-1:0] sec1_rows,
  output logic [ROWS_W-1:0] sec2_rows
);
  import hvp_pkg::*;

  localparam int NBANK = 2;

  logic par_we;
  logic zone_we;

  hv_set_t [NBANK-1:0] bank_q;
  hv_set_t [NBANK-1:0] bank_nxt;
  hv_set_t             act_q;

  hvp_cmd_gate #(.KIND_W(KIND_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .ext_flag  (ext_flag),
    .par_we    (par_we),
    .zone_we   (zone_we)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_we;
    assign bank_we = par_we && (mode_i == b[0]);
    hvp_bank #(.KIND_W(KIND_W), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .we      (bank_we),
      .kind    (cmd_kind),
      .data    (cmd_data),
      .set_q   (bank_q[b]),
      .set_nxt (bank_nxt[b])
    );
  end

  hvp_out_stage #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode_i),
    .rd_sel   (rd_sel),
    .bank_nxt (bank_nxt),
    .act_q    (act_q),
    .mode_q   (mode_q),
    .rd_data  (rd_data)
  );

  hvp_zone #(.DATA_W(DATA_W), .ZONE_W(ZONE_W), .ROWS_W(ROWS_W)) u_zone (
    .clk    (clk),
    .rst    (rst),
    .we     (zone_we),
    .data   (cmd_data),
    .code_q (zone_code),
    .sec1_q (sec1_rows),
    .sec2_q (sec2_rows)
  );

  assign hv_rsel = act_q.rsel;
  assign hv_vop  = act_q.vop;
  assign hv_bias = act_q.bias;
  assign hv_pump = act_q.pump;
endmodule

// File: rtl/hv_param_banks_chk.sv
module hv_param_banks_chk #(
  parameter int ROWS_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic              ext_flag,
  input logic              mode_i,
  input logic              mode_q,
  input logic [1:0]        hv_rsel,
  input logic [6:0]        hv_vop,
  input logic [2:0]        hv_bias,
  input logic [2:0]        hv_pump,
  input logic [ROWS_W-1:0] sec1_rows,
  input logic [ROWS_W-1:0] sec2_rows,
  input hvp_pkg::hv_set_t  norm_q,
  input hvp_pkg::hv_set_t  part_q
);
  logic ext_seen;
  always_ff @(posedge clk) begin
    if (rst) ext_seen <= 1'b0;
    else     ext_seen <= ext_flag;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (hv_rsel == '0 && hv_vop == '0 && hv_bias == '0 && hv_pump == '0 && mode_q == 1'b0));

  // R5
  mode_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mode_q == $past(mode_i)));

  // R5
  out_bank_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({hv_rsel, hv_vop, hv_bias, hv_pump} == (mode_q ? part_q : norm_q)));

  // R6
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && ext_flag && ext_seen) |=> ($stable(norm_q) && $stable(part_q)));

  // R2
  norm_only_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_i |=> $stable(part_q));

  // R3
  part_only_chk: assert property (@(posedge clk) disable iff (rst)
    mode_i |=> $stable(norm_q));

  // R10
  bad_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == 3'd0 || cmd_kind > 3'd5) |=> ($stable(norm_q) && $stable(part_q)));

  // R8
  zone_legal_chk: assert property (@(posedge clk) disable iff (rst)
    ((sec1_rows != '0 || sec2_rows != '0) && sec1_rows[2:0] == 3'd0 && sec2_rows[2:0] == 3'd0));
endmodule

bind hv_param_banks hv_param_banks_chk #(.ROWS_W(ROWS_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_kind  (3'(cmd_kind)),
  .ext_flag  (ext_flag),
  .mode_i    (mode_i),
  .mode_q    (mode_q),
  .hv_rsel   (hv_rsel),
  .hv_vop    (hv_vop),
  .hv_bias   (hv_bias),
  .hv_pump   (hv_pump),
  .sec1_rows (sec1_rows),
  .sec2_rows (sec2_rows),
  .norm_q    (bank_q[0]),
  .part_q    (bank_q[1])
);

// File: tb/test_hv_param_banks.sv
module test_hv_param_banks;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_kind = 3'd0;
  logic [6:0] cmd_data = 7'd0;
  logic       ext_flag = 1'b0;
  logic       mode_i = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [1:0] hv_rsel;
  logic [6:0] hv_vop;
  logic [2:0] hv_bias;
  logic [2:0] hv_pump;
  logic       mode_q;
  logic [6:0] rd_data;
  logic [2:0] zone_code;
  logic [4:0] sec1_rows;
  logic [4:0] sec2_rows;

  int errors = 0;
  int checks = 0;
  int ex[2][4];
  int zc = 0;
  logic ext_prev_m = 1'b0;

  always #10 clk = ~clk;

  hv_param_banks i_hv_param_banks (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_data(cmd_data), .ext_flag(ext_flag), .mode_i(mode_i), .rd_sel(rd_sel),
    .hv_rsel(hv_rsel), .hv_vop(hv_vop), .hv_bias(hv_bias), .hv_pump(hv_pump),
    .mode_q(mode_q), .rd_data(rd_data), .zone_code(zone_code),
    .sec1_rows(sec1_rows), .sec2_rows(sec2_rows)
  );

  function automatic int s1_of(int c);
    int t[8] = '{0, 8, 8, 0, 16, 8, 16, 16};
    return t[c];
  endfunction
  function automatic int s2_of(int c);
    int t[8] = '{8, 0, 8, 16, 0, 16, 8, 16};
    return t[c];
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    int m = int'(mode_i);
    check(req, "mode_q", int'(mode_q), m);
    check(req, "rsel", int'(hv_rsel), ex[m][0]);
    check(req, "vop", int'(hv_vop), ex[m][1]);
    check(req, "bias", int'(hv_bias), ex[m][2]);
    check(req, "pump", int'(hv_pump), ex[m][3]);
    check(req, "sec1", int'(sec1_rows), s1_of(zc));
    check(req, "sec2", int'(sec2_rows), s2_of(zc));
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // One cycle: drive the command, update the model, clock.
  task automatic cyc(bit v, int kind, int data);
    int m = int'(mode_i);
    bit acc;
    cmd_valid = v; cmd_kind = 3'(kind); cmd_data = 7'(data);
    acc = v && ext_flag && ext_prev_m;
    if (acc && kind >= 2 && kind <= 5) begin
      case (kind)
        2: ex[m][0] = data & 3;
        3: ex[m][1] = data & 127;
        4: ex[m][2] = data & 7;
        default: ex[m][3] = data & 7;
      endcase
    end
    if (v && kind == 1) zc = data & 7;
    ext_prev_m = ext_flag;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick();
    for (int b = 0; b < 2; b++) for (int f = 0; f < 4; f++) ex[b][f] = 0;
    zc = 0; ext_prev_m = 1'b0;
    check_all("R1");
    check("R1", "rd_data", int'(rd_data), 0);
    rst = 1'b0;
    cyc(0, 0, 0);
    check_all("R1");
  endtask

  task automatic t_normal();
    mode_i = 1'b0; ext_flag = 1'b1;
    cyc(0, 0, 0);
    cyc(1, 3, 7'h55);
    cyc(1, 2, 7'h7F);
    cyc(1, 4, 7'h0D);
    cyc(1, 5, 7'h06);
    check("R2", "vop", int'(hv_vop), 'h55);
    check("R4", "rsel trunc", int'(hv_rsel), 3);
    check("R4", "bias trunc", int'(hv_bias), 5);
    check_all("R2");
  endtask

  task automatic t_partial();
    mode_i = 1'b1;
    cyc(0, 0, 0);
    check_all("R5");
    check("R5", "vop swap", int'(hv_vop), 0);
    cyc(1, 3, 7'h2A);
    cyc(1, 5, 7'h7F);
    check("R3", "vop", int'(hv_vop), 'h2A);
    check("R4", "pump trunc", int'(hv_pump), 7);
    mode_i = 1'b0;
    cyc(0, 0, 0);
    check("R3", "normal vop kept", int'(hv_vop), 'h55);
    check_all("R3");
  endtask

  task automatic t_ext_gate();
    mode_i = 1'b0; ext_flag = 1'b0;
    cyc(0, 0, 0);
    ext_flag = 1'b1;
    cyc(1, 3, 7'h11);
    check("R6", "unarmed write ignored", int'(hv_vop), 'h55);
    cyc(1, 3, 7'h12);
    check("R6", "armed write", int'(hv_vop), 'h12);
    ext_flag = 1'b0;
    cyc(1, 3, 7'h13);
    check("R6", "flag low ignored", int'(hv_vop), 'h12);
    check_all("R6");
  endtask

  task automatic t_readback();
    mode_i = 1'b0;
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      tick();
      check("R7", "rd normal", int'(rd_data), ex[0][s]);
    end
    mode_i = 1'b1; rd_sel = 2'd1;
    tick();
    check("R7", "rd partial", int'(rd_data), ex[1][1]);
    mode_i = 1'b0;
    tick();
  endtask

  task automatic t_zone();
    ext_flag = 1'b0;
    for (int c = 0; c < 8; c++) begin
      cyc(1, 1, c + 8);
      check("R8", "zone code", int'(zone_code), c);
      check("R8", "sec1", int'(sec1_rows), s1_of(c));
      check("R8", "sec2", int'(sec2_rows), s2_of(c));
    end
    cyc(1, 1, 5);
  endtask

  task automatic t_collision();
    mode_i = 1'b0; ext_flag = 1'b1;
    cyc(0, 0, 0);
    mode_i = 1'b1;
    cyc(1, 3, 7'h33);
    check("R9", "vop same edge", int'(hv_vop), 'h33);
    check("R9", "pump partial", int'(hv_pump), 7);
    check_all("R9");
  endtask

  task automatic t_bad_kind();
    mode_i = 1'b1; ext_flag = 1'b1;
    cyc(0, 0, 0);
    cyc(1, 0, 7'h7F);
    cyc(1, 6, 7'h7F);
    cyc(1, 7, 7'h7F);
    check_all("R10");
    mode_i = 1'b0;
    cyc(0, 0, 0);
    check_all("R10");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_normal();
        t_partial();
        t_ext_gate();
        t_readback();
        t_zone();
        t_collision();
        t_bad_kind();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule